// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block is the control sequencer of a small 4-bit accumulator processor. Each cycle it looks at the nibble on the shared data lines, the memory handshake, a restart line, an interrupt line and two fed-back class bits. From these it drives strobes for the program counter, register A, the accumulator, the ALU operation code and bus steering, and it sets the read/write direction of external memory. Arithmetic instructions finish in the cycle their opcode is taken. Memory and branch instructions take an 8-bit operand address from the next two program nibbles, low nibble first, and then perform their final step.

The sequencer has five states: idle, fetch, address-low, address-high and execute. Every multi-cycle instruction passes through the same two address states. When fetch decodes such an opcode, the sequencer puts a 2-bit class code on `fb_set` and pulses `fb_latch`. An external latch holds the code and returns it on `fb_in`, and only the execute state reads it. The opcode table is a parameter.

Memory data arrives on a valid/ready-style handshake in which memory supplies only the valid side. `mem_ready` marks the cycle in which `data_nib` holds a valid nibble, or in which a write completes. The sequencer cannot push back on memory. It holds its state until `mem_ready` is seen and consumes the nibble in that cycle. All outputs are decoded combinationally from the state register and the current inputs.

Top module: `ctl_seq`

## Requirements
- R1: While `restart` is high, and in the first cycle after it is released, the sequencer is idle. In idle, `pc_clear` is 1 and every other output is 0.
- R2: Idle persists while `irq` is 0. A cycle in idle with `irq` at 1 moves the sequencer to fetch on the next cycle.
- R3: In fetch, address-low and address-high, a cycle with `mem_ready` at 0 drives every output to 0 and keeps the state unchanged.
- R4: The default opcode table is: add 1, subtract 2, shift-left 3, shift-right 4, load register A 8, load accumulator 9, store accumulator 10, branch 11. An arithmetic opcode taken in fetch with `mem_ready` high asserts `pc_inc`, `acc_en` and `alu_strobe`, and drives `alu_op` with add 0, subtract 1, shift-left 2 or shift-right 3. The sequencer stays in fetch.
- R5: A multi-cycle opcode taken in fetch asserts `pc_inc` and `fb_latch` and drives `fb_set` with the class code: store 0, load register A 1, load accumulator 2, branch 3. The next state is address-low.
- R6: An accepted address-low cycle asserts `pc_lat_lo`, `bus_to_pc` and `pc_inc`. The address-high cycle that follows asserts `pc_lat_hi`, `bus_to_pc` and `pc_inc`. The low nibble is always taken before the high nibble.
- R7: In execute, the class comes only from `fb_in`. For a load class, `pc_sel_b` stays 1 while the sequencer waits. On the `mem_ready` cycle it adds `bus_to_areg`+`areg_en` (class 1) or `bus_to_acc`+`acc_en` (class 2).
- R8: Store execute holds `pc_sel_b`, `mem_write` and `acc_to_bus` at 1 until the `mem_ready` cycle and asserts no register enable.
- R9: Branch execute lasts exactly one cycle, asserts only `pc_load_b`, and does not wait for `mem_ready`.
- R10: An opcode absent from the table asserts only `pc_inc` and leaves the sequencer in fetch.
- R11: In every cycle, at most one of `pc_clear`, `pc_lat_lo`, `pc_lat_hi`, `pc_load_b`, `areg_en`, `acc_en`, `fb_latch` is 1.
- R12: After the final cycle of any instruction, the next state is fetch.
- R13: Raising `restart` in any state forces idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| restart | input | 1 | Asynchronous restart to idle, active high |
| irq | input | 1 | Interrupt that leaves idle |
| mem_ready | input | 1 | Memory handshake: data valid or write done |
| data_nib | input | NIB_W | Shared data nibble (opcode or address) |
| fb_in | input | 2 | Latched instruction class |
| pc_sel_b | output | 1 | Select program-counter register B as address |
| pc_inc | output | 1 | Increment program counter |
| pc_clear | output | 1 | Clear program counter to zero |
| pc_lat_lo | output | 1 | Latch low address nibble into register B |
| pc_lat_hi | output | 1 | Latch high address nibble into register B |
| bus_to_pc | output | 1 | Steer data lines to program counter |
| areg_en | output | 1 | Register A write enable |
| acc_en | output | 1 | Accumulator write enable |
| alu_op | output | 3 | ALU operation code |
| alu_strobe | output | 1 | ALU input/output latch strobe |
| fb_set | output | 2 | Class code to the feedback latch |
| fb_latch | output | 1 | Capture strobe for the feedback latch |
| bus_to_areg | output | 1 | Steer data lines to register A |
| bus_to_acc | output | 1 | Steer data lines to accumulator |
| mem_write | output | 1 | Memory direction: 1 write, 0 read |
| acc_to_bus | output | 1 | Accumulator drives data lines |
| pc_load_b | output | 1 | Load program counter from register B |

## Verification
The bench runs all sixteen opcodes, each once with no wait cycles and once with a wait cycle before every handshaked step. It models the feedback latch itself and puts a branch opcode on the data lines during execute. A sequencer that decoded the live nibble in execute would then branch instead of loading or storing. A sequencer that ignored `mem_ready` would latch address nibbles or fire register enables during wait cycles. A branch that waited for memory would show a second `pc_load_b` cycle. Other faults show up as wrong class codes, a swapped low/high order, an unknown opcode that leaves fetch, idle exiting without an interrupt, and a restart in the middle of an instruction that fails to clear the program counter.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int ALU_W = 3;
  localparam int CLS_W = 2;
  localparam int N_OPS = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_ADLO  = 3'd2,
    ST_ADHI  = 3'd3,
    ST_EXEC  = 3'd4
  } state_t;

  typedef enum logic [CLS_W-1:0] {
    CL_STORE  = 2'd0,
    CL_LDREG  = 2'd1,
    CL_LDACC  = 2'd2,
    CL_BRANCH = 2'd3
  } cls_t;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_SHL = 3'd2,
    ALU_SHR = 3'd3
  } alu_t;

  typedef struct packed {
    logic is_alu;
    logic is_multi;
    alu_t alu;
    cls_t cls;
  } dec_t;

  typedef struct packed {
    logic pc_sel_b;
    logic pc_inc;
    logic pc_clear;
    logic pc_lat_lo;
    logic pc_lat_hi;
    logic bus_to_pc;
    logic areg_en;
    logic acc_en;
    alu_t alu_op;
    logic alu_strobe;
    cls_t fb_set;
    logic fb_latch;
    logic bus_to_areg;
    logic bus_to_acc;
    logic mem_write;
    logic acc_to_bus;
    logic pc_load_b;
  } ctl_t;

endpackage

// File: rtl/ctl_seq_dec.sv
module ctl_seq_dec
  import ctl_seq_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter logic [N_OPS*NIB_W-1:0] OPMAP = {4'hB, 4'hA, 4'h9, 4'h8, 4'h4, 4'h3, 4'h2, 4'h1}
) (
  input  logic [NIB_W-1:0] nib,
  output dec_t             dec
);

  logic [N_OPS-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_OPS; gi++) begin : g_match
      assign hit[gi] = (nib == OPMAP[gi*NIB_W +: NIB_W]);
    end
  endgenerate

  always_comb begin
    dec = '0;
    if (hit[0]) begin
      dec.is_alu = 1'b1; dec.alu = ALU_ADD;
    end else if (hit[1]) begin
      dec.is_alu = 1'b1; dec.alu = ALU_SUB;
    end else if (hit[2]) begin
      dec.is_alu = 1'b1; dec.alu = ALU_SHL;
    end else if (hit[3]) begin
      dec.is_alu = 1'b1; dec.alu = ALU_SHR;
    end else if (hit[4]) begin
      dec.is_multi = 1'b1; dec.cls = CL_LDREG;
    end else if (hit[5]) begin
      dec.is_multi = 1'b1; dec.cls = CL_LDACC;
    end else if (hit[6]) begin
      dec.is_multi = 1'b1; dec.cls = CL_STORE;
    end else if (hit[7]) begin
      dec.is_multi = 1'b1; dec.cls = CL_BRANCH;
    end
  end

endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
  import ctl_seq_pkg::*;
(
  input  logic   clk,
  input  logic   restart,
  input  logic   irq,
  input  logic   mem_ready,
  input  logic   op_multi,
  input  cls_t   fb_cls,
  output state_t state
);

  state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (irq) nxt = ST_FETCH;
      ST_FETCH: if (mem_ready && op_multi) nxt = ST_ADLO;
      ST_ADLO:  if (mem_ready) nxt = ST_ADHI;
      ST_ADHI:  if (mem_ready) nxt = ST_EXEC;
      ST_EXEC:  if (fb_cls == CL_BRANCH || mem_ready) nxt = ST_FETCH;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge restart) begin
    if (restart) state <= ST_IDLE;
    else         state <= nxt;
  end

endmodule

// File: rtl/ctl_seq_out.sv
module ctl_seq_out
  import ctl_seq_pkg::*;
(
  input  state_t state,
  input  logic   mem_ready,
  input  dec_t   dec,
  input  cls_t   fb_cls,
  output ctl_t   o
);

  always_comb begin
    o = '0;
    case (state)
      ST_IDLE: o.pc_clear = 1'b1;
      ST_FETCH: begin
        if (mem_ready) begin
          o.pc_inc = 1'b1;
          if (dec.is_alu) begin
            o.acc_en     = 1'b1;
            o.alu_strobe = 1'b1;
            o.alu_op     = dec.alu;
          end else if (dec.is_multi) begin
            o.fb_set   = dec.cls;
            o.fb_latch = 1'b1;
          end
        end
      end
      ST_ADLO: begin
        if (mem_ready) begin
          o.pc_lat_lo = 1'b1;
          o.bus_to_pc = 1'b1;
          o.pc_inc    = 1'b1;
        end
      end
      ST_ADHI: begin
        if (mem_ready) begin
          o.pc_lat_hi = 1'b1;
          o.bus_to_pc = 1'b1;
          o.pc_inc    = 1'b1;
        end
      end
      ST_EXEC: begin
        case (fb_cls)
          CL_BRANCH: o.pc_load_b = 1'b1;
          CL_STORE: begin
            o.pc_sel_b   = 1'b1;
            o.mem_write  = 1'b1;
            o.acc_to_bus = 1'b1;
          end
          CL_LDREG: begin
            o.pc_sel_b = 1'b1;
            if (mem_ready) begin
              o.bus_to_areg = 1'b1;
              o.areg_en     = 1'b1;
            end
          end
          CL_LDACC: begin
            o.pc_sel_b = 1'b1;
            if (mem_ready) begin
              o.bus_to_acc = 1'b1;
              o.acc_en     = 1'b1;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter logic [N_OPS*NIB_W-1:0] OPMAP = {4'hB, 4'hA, 4'h9, 4'h8, 4'h4, 4'h3, 4'h2, 4'h1}
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             irq,
  input  logic             mem_ready,
  input  logic [NIB_W-1:0] data_nib,
  input  logic [CLS_W-1:0] fb_in,
  output logic             pc_sel_b,
  output logic             pc_inc,
  output logic             pc_clear,
  output logic             pc_lat_lo,
  output logic             pc_lat_hi,
  output logic             bus_to_pc,
  output logic             areg_en,
  output logic             acc_en,
  output logic [ALU_W-1:0] alu_op,
  output logic             alu_strobe,
  output logic [CLS_W-1:0] fb_set,
  output logic             fb_latch,
  output logic             bus_to_areg,
  output logic             bus_to_acc,
  output logic             mem_write,
  output logic             acc_to_bus,
  output logic             pc_load_b
);

  dec_t   dec;
  state_t state;
  ctl_t   o;
  cls_t   fb_cls;

  assign fb_cls = cls_t'(fb_in);

  ctl_seq_dec #(.NIB_W(NIB_W), .OPMAP(OPMAP)) u_dec (
    .nib (data_nib),
    .dec (dec)
  );

  ctl_seq_fsm u_fsm (
    .clk       (clk),
    .restart   (restart),
    .irq       (irq),
    .mem_ready (mem_ready),
    .op_multi  (dec.is_multi),
    .fb_cls    (fb_cls),
    .state     (state)
  );

  ctl_seq_out u_out (
    .state     (state),
    .mem_ready (mem_ready),
    .dec       (dec),
    .fb_cls    (fb_cls),
    .o         (o)
  );

  assign pc_sel_b    = o.pc_sel_b;
  assign pc_inc      = o.pc_inc;
  assign pc_clear    = o.pc_clear;
  assign pc_lat_lo   = o.pc_lat_lo;
  assign pc_lat_hi   = o.pc_lat_hi;
  assign bus_to_pc   = o.bus_to_pc;
  assign areg_en     = o.areg_en;
  assign acc_en      = o.acc_en;
  assign alu_op      = o.alu_op;
  assign alu_strobe  = o.alu_strobe;
  assign fb_set      = o.fb_set;
  assign fb_latch    = o.fb_latch;
  assign bus_to_areg = o.bus_to_areg;
  assign bus_to_acc  = o.bus_to_acc;
  assign mem_write   = o.mem_write;
  assign acc_to_bus  = o.acc_to_bus;
  assign pc_load_b   = o.pc_load_b;

endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk
  import ctl_seq_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             restart,
  input logic             irq,
  input logic             mem_ready,
  input logic [NIB_W-1:0] data_nib,
  input logic [CLS_W-1:0] fb_in,
  input logic             pc_sel_b,
  input logic             pc_inc,
  input logic             pc_clear,
  input logic             pc_lat_lo,
  input logic             pc_lat_hi,
  input logic             bus_to_pc,
  input logic             areg_en,
  input logic             acc_en,
  input logic [ALU_W-1:0] alu_op,
  input logic             alu_strobe,
  input logic [CLS_W-1:0] fb_set,
  input logic             fb_latch,
  input logic             bus_to_areg,
  input logic             bus_to_acc,
  input logic             mem_write,
  input logic             acc_to_bus,
  input logic             pc_load_b
);

  logic lo_seen;

  always_ff @(posedge clk or posedge restart) begin
    if (restart)        lo_seen <= 1'b0;
    else if (pc_lat_lo) lo_seen <= 1'b1;
    else if (pc_lat_hi) lo_seen <= 1'b0;
  end

  a_r1_idle_after_restart: assert property (@(posedge clk) disable iff (restart)
    $past(restart) |-> pc_clear);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (restart)
    (pc_clear && !irq) |=> pc_clear);

  a_r3_no_accept_without_ready: assert property (@(posedge clk) disable iff (restart)
    !mem_ready |-> !(pc_inc || pc_lat_lo || pc_lat_hi || areg_en || acc_en || fb_latch || alu_strobe));

  a_r6_low_before_high: assert property (@(posedge clk) disable iff (restart)
    pc_lat_hi |-> lo_seen);

  a_r9_branch_single: assert property (@(posedge clk) disable iff (restart)
    pc_load_b |=> !pc_load_b);

  a_r5_latch_single: assert property (@(posedge clk) disable iff (restart)
    fb_latch |=> !fb_latch);

  a_r11_one_enable: assert property (@(posedge clk) disable iff (restart)
    $onehot0({pc_clear, pc_lat_lo, pc_lat_hi, pc_load_b, areg_en, acc_en, fb_latch}));

endmodule

bind ctl_seq ctl_seq_chk #(.NIB_W(NIB_W)) u_chk (.*);

// File: tb/tb_ctl_seq.sv
module tb_ctl_seq;

  localparam int CLK_PERIOD = 10;

  localparam logic [19:0] B_SELB = 20'h80000;
  localparam logic [19:0] B_INC  = 20'h40000;
  localparam logic [19:0] B_CLR  = 20'h20000;
  localparam logic [19:0] B_LO   = 20'h10000;
  localparam logic [19:0] B_HI   = 20'h08000;
  localparam logic [19:0] B_BPC  = 20'h04000;
  localparam logic [19:0] B_AEN  = 20'h02000;
  localparam logic [19:0] B_CEN  = 20'h01000;
  localparam logic [19:0] B_STB  = 20'h00100;
  localparam logic [19:0] B_FBL  = 20'h00020;
  localparam logic [19:0] B_BAR  = 20'h00010;
  localparam logic [19:0] B_BAC  = 20'h00008;
  localparam logic [19:0] B_WR   = 20'h00004;
  localparam logic [19:0] B_A2B  = 20'h00002;
  localparam logic [19:0] B_LDB  = 20'h00001;

  logic       clk = 1'b0;
  logic       restart = 1'b1;
  logic       irq = 1'b0;
  logic       mem_ready = 1'b0;
  logic [3:0] data_nib = 4'h0;
  logic [1:0] fb_in;
  logic       pc_sel_b, pc_inc, pc_clear, pc_lat_lo, pc_lat_hi, bus_to_pc;
  logic       areg_en, acc_en, alu_strobe, fb_latch, bus_to_areg, bus_to_acc;
  logic       mem_write, acc_to_bus, pc_load_b;
  logic [2:0] alu_op;
  logic [1:0] fb_set;
  logic [1:0] fb_q;
  logic [19:0] got;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // feedback latch of the surrounding datapath
  always_ff @(posedge clk or posedge restart) begin
    if (restart)       fb_q <= 2'd0;
    else if (fb_latch) fb_q <= fb_set;
  end
  assign fb_in = fb_q;

  ctl_seq dut (
    .clk(clk), .restart(restart), .irq(irq), .mem_ready(mem_ready),
    .data_nib(data_nib), .fb_in(fb_in),
    .pc_sel_b(pc_sel_b), .pc_inc(pc_inc), .pc_clear(pc_clear),
    .pc_lat_lo(pc_lat_lo), .pc_lat_hi(pc_lat_hi), .bus_to_pc(bus_to_pc),
    .areg_en(areg_en), .acc_en(acc_en), .alu_op(alu_op), .alu_strobe(alu_strobe),
    .fb_set(fb_set), .fb_latch(fb_latch), .bus_to_areg(bus_to_areg),
    .bus_to_acc(bus_to_acc), .mem_write(mem_write), .acc_to_bus(acc_to_bus),
    .pc_load_b(pc_load_b)
  );

  assign got = {pc_sel_b, pc_inc, pc_clear, pc_lat_lo, pc_lat_hi, bus_to_pc,
                areg_en, acc_en, alu_op, alu_strobe, fb_set, fb_latch,
                bus_to_areg, bus_to_acc, mem_write, acc_to_bus, pc_load_b};

  function automatic logic [19:0] alu_bits(int code);
    return 20'(code) << 9;
  endfunction

  function automatic logic [19:0] cls_bits(int c);
    return 20'(c) << 6;
  endfunction

  // opcode kinds: 0 unknown, 1 arithmetic, 2 multi-cycle
  function automatic int op_kind(int op);
    if (op >= 1 && op <= 4) return 1;
    if (op >= 8 && op <= 11) return 2;
    return 0;
  endfunction

  function automatic int op_cls(int op);
    case (op)
      8:  return 1;
      9:  return 2;
      10: return 0;
      default: return 3;
    endcase
  endfunction

  task automatic drive(input logic rdy, input logic [3:0] nib);
    mem_ready = rdy;
    data_nib  = nib;
  endtask

  // inputs are set at posedge+1; outputs are checked at the falling edge
  task automatic cyc(input string tag, input logic [19:0] exp);
    @(negedge clk);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %05h expected %05h", tag, got, exp);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic run_op(input int op, input bit stall);
    int kind;
    int c;
    kind = op_kind(op);
    if (stall) begin
      drive(1'b0, 4'(op));
      cyc("R3 fetch wait", 20'h0);
    end
    drive(1'b1, 4'(op));
    if (kind == 1)
      cyc("R4 arithmetic fetch", B_INC | B_CEN | B_STB | alu_bits(op - 1));
    else if (kind == 0)
      cyc("R10 unknown opcode", B_INC);
    else begin
      c = op_cls(op);
      cyc("R5 multi fetch", B_INC | B_FBL | cls_bits(c));
      if (stall) begin
        drive(1'b0, 4'h5);
        cyc("R3 addr-low wait", 20'h0);
      end
      drive(1'b1, 4'h6);
      cyc("R6 addr low", B_LO | B_BPC | B_INC);
      if (stall) begin
        drive(1'b0, 4'h7);
        cyc("R3 addr-high wait", 20'h0);
      end
      drive(1'b1, 4'h8);
      cyc("R6 addr high", B_HI | B_BPC | B_INC);
      if (c == 3) begin
        drive(1'b0, 4'hB);
        cyc("R9 branch", B_LDB);
      end else begin
        if (stall) begin
          drive(1'b0, 4'hB);
          if (c == 0) cyc("R8 store wait", B_SELB | B_WR | B_A2B);
          else        cyc("R7 load wait", B_SELB);
        end
        drive(1'b1, 4'hB);
        if (c == 0)      cyc("R8 store done", B_SELB | B_WR | B_A2B);
        else if (c == 1) cyc("R7 load reg A", B_SELB | B_BAR | B_AEN);
        else             cyc("R7 load acc", B_SELB | B_BAC | B_CEN);
      end
    end
    // R12: the next cycle is fetch, so a held subtract opcode executes
    drive(1'b1, 4'h2);
    cyc("R12 back to fetch", B_INC | B_CEN | B_STB | alu_bits(1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    drive(1'b1, 4'h1);
    @(negedge clk);
    n_checks++;
    if (got !== B_CLR) begin
      n_errors++;
      $display("FAIL R1 during restart: got %05h expected %05h", got, B_CLR);
    end
    @(posedge clk);
    @(posedge clk);
    #1;
    restart = 1'b0;
    cyc("R1 idle after restart", B_CLR);
    for (int i = 0; i < 3; i++) cyc("R2 idle without irq", B_CLR);
    irq = 1'b1;
    cyc("R2 idle with irq", B_CLR);
    irq = 1'b0;

    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 16; op++)
        run_op(op, s[0]);

    // R13: restart in the middle of an instruction
    drive(1'b1, 4'h9);
    cyc("R5 fetch before restart", B_INC | B_FBL | cls_bits(2));
    drive(1'b1, 4'h3);
    cyc("R6 addr low before restart", B_LO | B_BPC | B_INC);
    restart = 1'b1;
    @(negedge clk);
    n_checks++;
    if (got !== B_CLR) begin
      n_errors++;
      $display("FAIL R13 restart mid-instruction: got %05h expected %05h", got, B_CLR);
    end
    @(posedge clk);
    #1;
    restart = 1'b0;
    cyc("R13 idle after restart", B_CLR);
    irq = 1'b1;
    cyc("R2 irq exit", B_CLR);
    irq = 1'b0;
    drive(1'b1, 4'h4);
    cyc("R4 shift right after restart", B_INC | B_CEN | B_STB | alu_bits(3));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule